// File: doc/BRIEF.md
# Rotating-Fast-Bit Memory Address Tester

This block is a self-running address test engine for a word-addressed synchronous memory. After a start pulse it runs one pass per address bit. Each pass has three phases:

- **Fill.** It writes every word in ascending order, using a pattern built from the word's own address.
- **Scramble.** It visits every word in a rotated order. One chosen address bit toggles fastest, and its carry runs upward and wraps around into the bits below it. At each word it reads, checks, and writes back the complement of what it read.
- **Verify.** It reads every word again in ascending order and expects the complemented pattern.

The fast bit starts at address bit 0 and moves up by one on each pass. A fault in the upper address decode, or in address translation between the tester and the array, therefore shows up only on the passes whose visiting order exposes it.

Every mismatch is reported as a one-cycle record on the error port, and the test keeps running. A sticky fail flag and a done level close the run.

The memory port has a fixed read latency of one cycle and carries no back-pressure. The memory must accept one request on every cycle, and the tester never issues more than one. The error port likewise has no ready: a record is presented for exactly one cycle and is not held.

Top module: `mem_tester`

## Requirements
- R1: After reset the tester is idle: mem_re, mem_we, err_valid, done and fail are all 0, and no request is issued until start is seen.
- R2: In the cycle after start is accepted, the fill phase begins. It writes word a at address a, for a = 0 up to the top address, one write per cycle. The data word carries the address in its upper half and the address complement in its lower half, {a, ~a}.
- R3: In the scramble phase of pass p, the k-th word visited has address rotl(k, p), for k counting up from 0. Here rotl is a rotation of the ADDR_W-bit value by p positions toward the most significant bit, so counter bit 0 drives address bit p.
- R4: Each scramble visit takes two cycles. The first cycle is a read. The second cycle is a write to the same address, carrying the bitwise complement of the word returned by that read.
- R5: The verify phase reads addresses 0 up to the top address in ascending order, one read per cycle, and expects ~{a, ~a} at address a.
- R6: There are ADDR_W passes with fast bits 0, 1, … ADDR_W-1. Every pass runs fill, then scramble, then verify, with no idle cycle between phases or between passes.
- R7: A mismatch is reported by a single-cycle err_valid, two cycles after the read was issued. The record gives the failing address, the expected and actual words, the phase code (1 = scramble, 2 = verify) and the fast bit of the pass.
- R8: An error does not stop or alter the request sequence. Every later mismatch is reported on its own.
- R9: done rises two cycles after the last verify read of the final pass and stays high until the next start. fail is high exactly when at least one error has been reported since the last accepted start, and it is cleared by that start.
- R10: A start pulse while a test is running is ignored, and the request sequence continues unchanged.
- R11: At most one of mem_re and mem_we is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle or done |
| done | output | 1 | Test complete, held until next start |
| fail | output | 1 | Sticky: an error occurred in this run |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 2*ADDR_W | Memory write data |
| mem_rdata | input | 2*ADDR_W | Memory read data, one cycle after mem_re |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| err_valid | output | 1 | One-cycle error record strobe |
| err_addr | output | ADDR_W | Failing address |
| err_expected | output | 2*ADDR_W | Expected word |
| err_actual | output | 2*ADDR_W | Word returned by memory |
| err_phase | output | 2 | 1 = scramble, 2 = verify |
| err_fast_bit | output | FB_W | Fast-bit position of the pass |

## Verification
The hardest situation to reach from the ports is a memory that misbehaves in a way that produces errors during a run. The scramble-phase and verify-phase error paths must both be exercised, on every pass, with a known position and timing.

The bench's memory model can force one data bit of one chosen word to stay at zero on every write. This yields exactly one error per pass. Whether that error lands in the scramble phase or the verify phase depends on the value the pattern places in that bit.

The table varies the faulty word and bit so that both phases are reached. The bench then checks the count, the fast-bit order, the first record's fields and its cycle against values it computes itself.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_SCRAM,
    ST_VERIFY,
    ST_FLUSH,
    ST_DONE
  } tst_state_t;

  localparam logic [1:0] PH_SCRAM  = 2'd1;
  localparam logic [1:0] PH_VERIFY = 2'd2;
endpackage

// File: rtl/mt_addr_walker.sv
module mt_addr_walker
  import mt_pkg::*;
#(
  parameter  int ADDR_W = 18,
  localparam int DATA_W = 2 * ADDR_W,
  localparam int FB_W   = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  output logic              mem_we,
  output logic              rd_issue,
  output logic [1:0]        rd_phase,
  output logic [FB_W-1:0]   rd_fast,
  output logic              start_acc,
  output logic              done
);
  tst_state_t        state;
  logic [ADDR_W-1:0] cnt;
  logic [FB_W-1:0]   fast;
  logic              sub;
  logic              last_cnt;
  logic              last_pass;
  logic [DATA_W-1:0] rot_wide;
  logic [ADDR_W-1:0] scr_addr;

  assign last_cnt  = &cnt;
  assign last_pass = (fast == FB_W'(ADDR_W - 1));
  // rotation toward the MSB: upper half of the doubled counter shifted by fast
  assign rot_wide  = {cnt, cnt} << fast;
  assign scr_addr  = rot_wide[DATA_W-1:ADDR_W];
  assign start_acc = start && (state == ST_IDLE || state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      fast  <= '0;
      sub   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: if (start) begin
          state <= ST_FILL;
          cnt   <= '0;
          fast  <= '0;
          sub   <= 1'b0;
        end
        ST_FILL: begin
          cnt <= cnt + 1'b1;
          if (last_cnt) state <= ST_SCRAM;
        end
        ST_SCRAM: begin
          sub <= ~sub;
          if (sub) begin
            cnt <= cnt + 1'b1;
            if (last_cnt) state <= ST_VERIFY;
          end
        end
        ST_VERIFY: begin
          cnt <= cnt + 1'b1;
          if (last_cnt) begin
            if (last_pass) state <= ST_FLUSH;
            else begin
              state <= ST_FILL;
              fast  <= fast + 1'b1;
            end
          end
        end
        ST_FLUSH: state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_re    = (state == ST_SCRAM && !sub) || (state == ST_VERIFY);
    mem_we    = (state == ST_FILL) || (state == ST_SCRAM && sub);
    mem_addr  = (state == ST_SCRAM) ? scr_addr : cnt;
    if (state == ST_FILL)  mem_wdata = {cnt, ~cnt};
    else if (mem_we)       mem_wdata = ~rd_data;
    else                   mem_wdata = '0;
    rd_issue  = mem_re;
    rd_phase  = (state == ST_SCRAM) ? PH_SCRAM : PH_VERIFY;
    rd_fast   = fast;
    done      = (state == ST_DONE);
  end

  // R4
  scram_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && state == ST_SCRAM) |=> (mem_we && $stable(mem_addr)));

  // R2
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL && !last_cnt) |=> (mem_we && mem_addr == $past(mem_addr) + 1'b1));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state == ST_SCRAM || state == ST_VERIFY)) |=> (state != ST_FILL || $past(last_cnt)));
endmodule

// File: rtl/mt_result_check.sv
module mt_result_check
  import mt_pkg::*;
#(
  parameter  int ADDR_W = 18,
  localparam int DATA_W = 2 * ADDR_W,
  localparam int FB_W   = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_issue,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_phase,
  input  logic [FB_W-1:0]   rd_fast,
  input  logic [DATA_W-1:0] rd_data,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_expected,
  output logic [DATA_W-1:0] err_actual,
  output logic [1:0]        err_phase,
  output logic [FB_W-1:0]   err_fast_bit,
  output logic              fail
);
  logic              p_valid;
  logic [ADDR_W-1:0] p_addr;
  logic [1:0]        p_phase;
  logic [FB_W-1:0]   p_fast;
  logic [DATA_W-1:0] pat;
  logic [DATA_W-1:0] exp_w;
  logic              mismatch;

  assign pat      = {p_addr, ~p_addr};
  assign exp_w    = (p_phase == PH_VERIFY) ? ~pat : pat;
  assign mismatch = p_valid && (rd_data != exp_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_valid      <= 1'b0;
      p_addr       <= '0;
      p_phase      <= '0;
      p_fast       <= '0;
      err_valid    <= 1'b0;
      err_addr     <= '0;
      err_expected <= '0;
      err_actual   <= '0;
      err_phase    <= '0;
      err_fast_bit <= '0;
      fail         <= 1'b0;
    end else begin
      p_valid   <= rd_issue;
      p_addr    <= rd_addr;
      p_phase   <= rd_phase;
      p_fast    <= rd_fast;
      err_valid <= mismatch;
      if (mismatch) begin
        err_addr     <= p_addr;
        err_expected <= exp_w;
        err_actual   <= rd_data;
        err_phase    <= p_phase;
        err_fast_bit <= p_fast;
      end
      if (clr)           fail <= 1'b0;
      else if (mismatch) fail <= 1'b1;
    end
  end

  // R7
  err_sets_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> fail);

  // R7
  err_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(p_valid));
endmodule

// File: rtl/mem_tester.sv
module mem_tester
  import mt_pkg::*;
#(
  parameter  int ADDR_W = 18,
  localparam int DATA_W = 2 * ADDR_W,
  localparam int FB_W   = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_re,
  output logic              mem_we,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_expected,
  output logic [DATA_W-1:0] err_actual,
  output logic [1:0]        err_phase,
  output logic [FB_W-1:0]   err_fast_bit
);
  logic            rd_issue;
  logic [1:0]      rd_phase;
  logic [FB_W-1:0] rd_fast;
  logic            start_acc;

  mt_addr_walker #(.ADDR_W(ADDR_W)) walker_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_data   (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .rd_issue  (rd_issue),
    .rd_phase  (rd_phase),
    .rd_fast   (rd_fast),
    .start_acc (start_acc),
    .done      (done)
  );

  mt_result_check #(.ADDR_W(ADDR_W)) check_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (start_acc),
    .rd_issue     (rd_issue),
    .rd_addr      (mem_addr),
    .rd_phase     (rd_phase),
    .rd_fast      (rd_fast),
    .rd_data      (mem_rdata),
    .err_valid    (err_valid),
    .err_addr     (err_addr),
    .err_expected (err_expected),
    .err_actual   (err_actual),
    .err_phase    (err_phase),
    .err_fast_bit (err_fast_bit),
    .fail         (fail)
  );

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_re, mem_we}));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_re && !mem_we));
endmodule

// File: tb/mem_tester_tb.sv
module mem_tester_tb_top;
  localparam int  AW      = 4;
  localparam int  DW      = 2 * AW;
  localparam int  N       = 1 << AW;
  localparam int  TOT     = 4 * N * AW;
  localparam time CLK_PER = 10ns;
  localparam int  NVEC    = 6;
  // {fault on, faulty word, stuck-at-0 bit}
  localparam logic [7:0] VEC [NVEC] = '{
    {1'b1, 4'd5,  3'd7},
    {1'b0, 4'd0,  3'd0},
    {1'b1, 4'd6,  3'd5},
    {1'b1, 4'd9,  3'd0},
    {1'b1, 4'd0,  3'd3},
    {1'b1, 4'd15, 3'd4}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          done, fail, mem_re, mem_we, err_valid;
  logic [AW-1:0] mem_addr, err_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, err_expected, err_actual;
  logic [1:0]    err_phase;
  logic [1:0]    err_fast_bit;

  int checks = 0;
  int errors = 0;

  logic          f_on = 1'b0;
  logic [AW-1:0] f_loc = '0;
  logic [2:0]    f_bit = '0;
  logic [DW-1:0] bmem [N];

  always #(CLK_PER / 2) clk = ~clk;

  mem_tester #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_re(mem_re), .mem_we(mem_we), .err_valid(err_valid),
    .err_addr(err_addr), .err_expected(err_expected), .err_actual(err_actual),
    .err_phase(err_phase), .err_fast_bit(err_fast_bit)
  );

  function automatic logic [DW-1:0] fmask(input logic [AW-1:0] a);
    return (f_on && a == f_loc) ? (DW'(1) << f_bit) : '0;
  endfunction

  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr] <= mem_wdata & ~fmask(mem_addr);
    if (mem_re) mem_rdata <= bmem[mem_addr];
  end

  initial mem_rdata = '0;

  function automatic logic [AW-1:0] rotl(input int k, input int p);
    logic [AW-1:0] v;
    v = AW'(k);
    return AW'((v << p) | (v >> (AW - p)));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input logic on, input logic [AW-1:0] loc,
                          input logic [2:0] bt, input bit poke);
    int fill_bad = 0, ord_bad = 0, wr_bad = 0, ver_bad = 0, done_bad = 0;
    int ecnt = 0, fast_bad = 0, first_idx = -1;
    logic [AW-1:0] e_addr = '0;
    logic [DW-1:0] e_exp = '0, e_act = '0;
    logic [1:0]    e_ph = '0;
    logic [DW-1:0] pat, m;
    bit            in_scr;
    int            exp_idx;
    f_on = on; f_loc = loc; f_bit = bt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < TOT + 2; i++) begin
      if (i > 0) @(negedge clk);
      if (poke && i == 50) start = 1'b1;   // R10: ignored while busy
      if (poke && i == 51) start = 1'b0;
      if (err_valid) begin
        if (ecnt == 0) begin
          first_idx = i; e_addr = err_addr; e_exp = err_expected;
          e_act = err_actual; e_ph = err_phase;
        end
        if (int'(err_fast_bit) != ecnt) fast_bad++;
        ecnt++;
      end
      if (i < TOT) begin
        int p, r;
        p = i / (4 * N);
        r = i % (4 * N);
        if (done) done_bad++;
        if (r < N) begin
          if (!(mem_we && !mem_re && mem_addr == AW'(r) &&
                mem_wdata == {AW'(r), ~AW'(r)})) fill_bad++;
        end else if (r < 3 * N) begin
          int k, s;
          k = (r - N) / 2;
          s = (r - N) % 2;
          if (mem_addr != rotl(k, p)) ord_bad++;
          if (s == 0 && !(mem_re && !mem_we)) ord_bad++;
          if (s == 1 && !(mem_we && !mem_re && mem_wdata == ~bmem[mem_addr])) wr_bad++;
        end else begin
          if (!(mem_re && !mem_we && mem_addr == AW'(r - 3 * N))) ver_bad++;
        end
      end else if (i == TOT) begin
        if (done || mem_re || mem_we) done_bad++;
      end else begin
        if (!done) done_bad++;
      end
    end
    chk(fill_bad == 0, "R2", "fill ops wrong", fill_bad, 0);
    chk(ord_bad == 0, "R3", "scramble order wrong", ord_bad, 0);
    chk(wr_bad == 0, "R4", "scramble writeback wrong", wr_bad, 0);
    chk(ver_bad == 0, "R5", "verify ops wrong", ver_bad, 0);
    chk(done_bad == 0, "R6", "pass length / done timing wrong", done_bad, 0);
    chk(ecnt == (on ? AW : 0), "R8", "error count", ecnt, on ? AW : 0);
    chk(fail == on, "R9", "fail flag", fail, on);
    if (on) begin
      pat = {loc, ~loc};
      m   = DW'(1) << bt;
      in_scr = pat[bt];
      chk(fast_bad == 0, "R6", "fast bit order in errors", fast_bad, 0);
      chk(e_addr == loc, "R7", "err_addr", e_addr, loc);
      chk(e_ph == (in_scr ? 2'd1 : 2'd2), "R7", "err_phase", e_ph, in_scr ? 1 : 2);
      chk(e_exp == (in_scr ? pat : ~pat), "R7", "err_expected", e_exp, in_scr ? pat : ~pat);
      chk(e_act == ((in_scr ? pat : ~pat) & ~m), "R7", "err_actual", e_act,
          (in_scr ? pat : ~pat) & ~m);
      exp_idx = (in_scr ? N + 2 * int'(loc) : 3 * N + int'(loc)) + 2;
      chk(first_idx == exp_idx, "R7", "error cycle", first_idx, exp_idx);
    end
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R9", "done held", done, 1);
  endtask

  initial begin
    #(CLK_PER * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!mem_re && !mem_we, "R1", "strobes in reset", {mem_re, mem_we}, 0);
    chk(!done && !fail && !err_valid, "R1", "status in reset", {done, fail, err_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_re && !mem_we && !done, "R1", "idle before start", {mem_re, mem_we, done}, 0);
    chk(!fail, "R1", "fail idle", fail, 0);
    for (int v = 0; v < NVEC; v++)
      run_case(VEC[v][7], VEC[v][6:3], VEC[v][2:0], v == 2);
    // R11 is also observed in every op check (re and we never together)
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule